// File: doc/BRIEF.md
# Network controller host register interface

This block is the processor-facing register front end of a token-passing network controller. It watches a synchronous I/O bus and claims a window of sixteen consecutive I/O locations. A 3-bit base select input places that window. Inside the window it answers reads of a status register and a diagnostic register. It accepts writes to an interrupt mask and to a command register. It drives a single interrupt request line from the stored status flags that the mask enables.

Status events, diagnostic events and the clearing of the receive and transmit flags come from core logic as single-cycle pulses. Every command write is passed back to the core as a one-cycle strobe with the written byte. One command, clear-flags, is also acted on inside this block. A synchronous software reset input from the core has the same effect as the hardware reset.

Top module: `nchi_host_if`

## Requirements
- R1: The window is claimed when `bus_aen_n` is 0 and `bus_addr[15:4]` equals 12'h020 + 2*`base_sel`, which places the window base at 0x200 + 0x20*`base_sel`. The register offset is `bus_addr[3:0]`.
- R2: While `bus_aen_n` is 1, or the address is outside the window, there is no access: reads load 8'h00 into `bus_rdata`, writes change no register, and no command strobe is produced.
- R3: A read at offset 0 returns the status image: bit 7 receiver-inhibited, bits 6:5 `core_live[1:0]` as sampled at the read, bit 4 reset flag, bit 3 transmit-acknowledged, bit 2 reconfiguration, bit 1 zero, bit 0 transmitter-available. Read data appears on `bus_rdata` one cycle after the read strobe and is held until the next read.
- R4: After hardware reset (`rst_n` low) or a `soft_rst` pulse: the stored status bits read as 1001_0001 with bits 6:5 live, the mask is 8'h00, the diagnostic bits are 0, and `irq`, `cmd_stb` and `bus_rdata` are 0.
- R5: The receiver-inhibited, transmitter-available and transmit-acknowledged flags are set by their `_set` pulse and cleared by their `_clr` pulse, one cycle later. A set and a clear in the same cycle leave the flag set.
- R6: A write at offset 0 loads the mask. The bit positions are the same as in the status register. `irq` is (bit7 & mask7) | (bit2 & mask2) | (bit0 & mask0) and follows a mask write or a flag change one cycle later.
- R7: The transmit-acknowledged flag (bit 3) and every mask bit other than 7, 2 and 0 never assert `irq`.
- R8: Clearing a mask bit hides a pending interrupt. Setting the mask bit again raises `irq` again if the flag is still set.
- R9: A write at offset 1 with data[2:0] = 3'b101 is the clear-flags command. Data bit 4 clears the reconfiguration flag and data bit 3 clears the reset flag. Apart from reset, nothing else clears these two flags. A `reconfig_evt` pulse in the same cycle leaves the reconfiguration flag set.
- R10: Three sticky diagnostic bits are set by `diag_evt[2]`, `[1]` and `[0]`. They read at bits 7, 5 and 4 of offset 1, and the other bits read 0. A read at offset 1 returns them and clears them. An event in the same cycle as the clearing read is kept.
- R11: Every write at offset 1 makes `cmd_stb` high for exactly one cycle, starting one cycle later, with `cmd_code` equal to the written byte.
- R12: Offsets 2 to 15 read as 8'h00, and writes to them have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous hardware reset, active low |
| soft_rst | input | 1 | Synchronous software reset pulse from the core |
| base_sel | input | 3 | Window base select |
| bus_aen_n | input | 1 | Address enable, decoding active when 0 |
| bus_addr | input | 16 | I/O address |
| bus_rd | input | 1 | Read strobe, one cycle per access |
| bus_wr | input | 1 | Write strobe, one cycle per access |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Registered read data |
| rx_inh_set | input | 1 | Set receiver-inhibited flag |
| rx_inh_clr | input | 1 | Clear receiver-inhibited flag |
| tx_avail_set | input | 1 | Set transmitter-available flag |
| tx_avail_clr | input | 1 | Clear transmitter-available flag |
| tx_ack_set | input | 1 | Set transmit-acknowledged flag |
| tx_ack_clr | input | 1 | Clear transmit-acknowledged flag |
| reconfig_evt | input | 1 | Set reconfiguration flag |
| core_live | input | 2 | Live core status shown at status bits 6:5 |
| diag_evt | input | 3 | Diagnostic event pulses |
| irq | output | 1 | Interrupt request |
| cmd_stb | output | 1 | One-cycle command strobe |
| cmd_code | output | 8 | Last command byte written |

## Verification
Read data, command strobes and stored flag or mask changes all take effect at the edge that samples the strobe or pulse. The matching output is therefore valid one cycle later. `irq` settles in that same cycle because it is formed from registered state only. The bench drives every input 1 ns after a rising edge and compares outputs 1 ns after the next rising edge. A bench-side model is advanced by exactly one edge per step, so each result is checked in the cycle it is due. Same-cycle corner cases are driven within a single step so that both inputs reach the same edge: set against clear, an event against a clearing read, and an event against clear-flags.

// File: rtl/nchi_pkg.sv
`timescale 1ns/1ps
package nchi_pkg;
    localparam int DW    = 8;
    localparam int OFS_W = 4;

    localparam logic [OFS_W-1:0] OFS_STAT = 4'h0;
    localparam logic [OFS_W-1:0] OFS_DIAG = 4'h1;

    localparam int B_RXINH  = 7;
    localparam int B_RSTFLG = 4;
    localparam int B_TXACK  = 3;
    localparam int B_RECON  = 2;
    localparam int B_TXAV   = 0;
    localparam int B_LIVE_LO = 5;

    localparam logic [DW-1:0] IRQ_CAPABLE = 8'h85;
    localparam logic [DW-1:0] FLAGS_RESET = 8'h91;

    localparam logic [2:0] CMD_CLRFLG   = 3'b101;
    localparam int         CLR_RST_BIT  = 3;
    localparam int         CLR_RECON_BIT = 4;

    localparam int N_DIAG = 3;
    localparam int DIAG_POS [N_DIAG] = '{4, 5, 7};

    typedef struct packed {
        logic [DW-1:0] flags;
        logic [DW-1:0] mask;
    } stat_st_t;

    typedef struct packed {
        logic [DW-1:0] rdata;
        logic          stb;
        logic [DW-1:0] code;
    } bus_st_t;
endpackage

// File: rtl/nchi_addr_dec.sv
`timescale 1ns/1ps
module nchi_addr_dec #(
    parameter int ADDR_W     = 16,
    parameter int OFS_W      = 4,
    parameter int SEL_W      = 3,
    parameter int BASE_TAG   = 'h020,
    parameter int STRIDE_LG2 = 1
) (
    input  logic [SEL_W-1:0]  sel,
    input  logic              aen_n,
    input  logic [ADDR_W-1:0] addr,
    output logic              hit,
    output logic [OFS_W-1:0]  ofs
);
    localparam int TAG_W = ADDR_W - OFS_W;

    logic [TAG_W-1:0] tag_exp;

    // expand the base select into the full upper-address compare value
    always_comb begin
        tag_exp = TAG_W'(BASE_TAG) + (TAG_W'(sel) << STRIDE_LG2);
        hit     = !aen_n && (addr[ADDR_W-1:OFS_W] == tag_exp);
        ofs     = addr[OFS_W-1:0];
    end
endmodule

// File: rtl/nchi_status.sv
`timescale 1ns/1ps
module nchi_status
    import nchi_pkg::*;
(
    input  logic          clk,
    input  logic          rst_n,
    input  logic          soft_rst,
    input  logic          mask_we,
    input  logic [DW-1:0] mask_wdata,
    input  logic          clr_rst_flag,
    input  logic          clr_recon,
    input  logic          rx_inh_set,
    input  logic          rx_inh_clr,
    input  logic          tx_avail_set,
    input  logic          tx_avail_clr,
    input  logic          tx_ack_set,
    input  logic          tx_ack_clr,
    input  logic          reconfig_evt,
    output logic [DW-1:0] flags,
    output logic [DW-1:0] mask,
    output logic          irq
);
    localparam int NPAIR = 3;
    localparam int PAIR_POS [NPAIR] = '{B_RXINH, B_TXAV, B_TXACK};

    stat_st_t st_d, st_q;
    logic [NPAIR-1:0] set_v, clr_v;

    assign set_v = {tx_ack_set, tx_avail_set, rx_inh_set};
    assign clr_v = {tx_ack_clr, tx_avail_clr, rx_inh_clr};

    always_comb begin
        st_d = st_q;
        for (int i = 0; i < NPAIR; i++) begin
            if (set_v[i])      st_d.flags[PAIR_POS[i]] = 1'b1;
            else if (clr_v[i]) st_d.flags[PAIR_POS[i]] = 1'b0;
        end
        if (reconfig_evt)   st_d.flags[B_RECON] = 1'b1;
        else if (clr_recon) st_d.flags[B_RECON] = 1'b0;
        if (clr_rst_flag)   st_d.flags[B_RSTFLG] = 1'b0;
        if (mask_we)        st_d.mask = mask_wdata;
        if (soft_rst) begin
            st_d.flags = FLAGS_RESET;
            st_d.mask  = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.flags <= FLAGS_RESET;
            st_q.mask  <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign flags = st_q.flags;
    assign mask  = st_q.mask;
    assign irq   = |(st_q.flags & st_q.mask & IRQ_CAPABLE);
endmodule

// File: rtl/nchi_diag.sv
`timescale 1ns/1ps
module nchi_diag
    import nchi_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              soft_rst,
    input  logic              rd_clr,
    input  logic [N_DIAG-1:0] evt,
    output logic [DW-1:0]     img
);
    logic [N_DIAG-1:0] dg_d, dg_q;

    // set wins over the clearing read so no event is dropped
    always_comb begin
        dg_d = rd_clr ? '0 : dg_q;
        dg_d = dg_d | evt;
        if (soft_rst) dg_d = '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) dg_q <= '0;
        else        dg_q <= dg_d;
    end

    always_comb begin
        img = '0;
        for (int i = 0; i < N_DIAG; i++) img[DIAG_POS[i]] = dg_q[i];
    end
endmodule

// File: rtl/nchi_host_if.sv
`timescale 1ns/1ps
module nchi_host_if
    import nchi_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int SEL_W  = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              soft_rst,
    input  logic [SEL_W-1:0]  base_sel,
    input  logic              bus_aen_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_rd,
    input  logic              bus_wr,
    input  logic [DW-1:0]     bus_wdata,
    output logic [DW-1:0]     bus_rdata,
    input  logic              rx_inh_set,
    input  logic              rx_inh_clr,
    input  logic              tx_avail_set,
    input  logic              tx_avail_clr,
    input  logic              tx_ack_set,
    input  logic              tx_ack_clr,
    input  logic              reconfig_evt,
    input  logic [1:0]        core_live,
    input  logic [N_DIAG-1:0] diag_evt,
    output logic              irq,
    output logic              cmd_stb,
    output logic [DW-1:0]     cmd_code
);
    logic             dec_hit;
    logic [OFS_W-1:0] dec_ofs;
    logic [DW-1:0]    st_flags, st_mask, dg_img, stat_img;
    logic             rd_stat, rd_diag, wr_mask, wr_cmd, clr_cmd;
    bus_st_t          bs_d, bs_q;

    nchi_addr_dec #(.ADDR_W(ADDR_W), .OFS_W(OFS_W), .SEL_W(SEL_W)) u_dec (
        .sel(base_sel), .aen_n(bus_aen_n), .addr(bus_addr),
        .hit(dec_hit), .ofs(dec_ofs)
    );

    always_comb begin
        rd_stat = bus_rd && dec_hit && (dec_ofs == OFS_STAT);
        rd_diag = bus_rd && dec_hit && (dec_ofs == OFS_DIAG);
        wr_mask = bus_wr && dec_hit && (dec_ofs == OFS_STAT) && !soft_rst;
        wr_cmd  = bus_wr && dec_hit && (dec_ofs == OFS_DIAG) && !soft_rst;
        clr_cmd = wr_cmd && (bus_wdata[2:0] == CMD_CLRFLG);
    end

    nchi_status u_stat (
        .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst),
        .mask_we(wr_mask), .mask_wdata(bus_wdata),
        .clr_rst_flag(clr_cmd && bus_wdata[CLR_RST_BIT]),
        .clr_recon(clr_cmd && bus_wdata[CLR_RECON_BIT]),
        .rx_inh_set(rx_inh_set), .rx_inh_clr(rx_inh_clr),
        .tx_avail_set(tx_avail_set), .tx_avail_clr(tx_avail_clr),
        .tx_ack_set(tx_ack_set), .tx_ack_clr(tx_ack_clr),
        .reconfig_evt(reconfig_evt),
        .flags(st_flags), .mask(st_mask), .irq(irq)
    );

    nchi_diag u_diag (
        .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst),
        .rd_clr(rd_diag), .evt(diag_evt), .img(dg_img)
    );

    always_comb begin
        stat_img = st_flags;
        stat_img[B_LIVE_LO +: 2] = core_live;
    end

    always_comb begin
        bs_d     = bs_q;
        bs_d.stb = wr_cmd;
        if (wr_cmd) bs_d.code = bus_wdata;
        if (bus_rd) begin
            if (rd_stat)      bs_d.rdata = stat_img;
            else if (rd_diag) bs_d.rdata = dg_img;
            else              bs_d.rdata = '0;
        end
        if (soft_rst) bs_d = '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) bs_q <= '0;
        else        bs_q <= bs_d;
    end

    assign bus_rdata = bs_q.rdata;
    assign cmd_stb   = bs_q.stb;
    assign cmd_code  = bs_q.code;
endmodule

// File: rtl/nchi_host_if_chk.sv
`timescale 1ns/1ps
module nchi_host_if_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       soft_rst,
    input logic       bus_aen_n,
    input logic       bus_rd,
    input logic       bus_wr,
    input logic [7:0] bus_wdata,
    input logic       hit,
    input logic [3:0] ofs,
    input logic [7:0] flags,
    input logic [7:0] mask,
    input logic [7:0] diag_img,
    input logic [2:0] diag_evt,
    input logic       reconfig_evt,
    input logic       irq,
    input logic       cmd_stb
);
    logic clr_recon_now;
    assign clr_recon_now = bus_wr && hit && (ofs == 4'h1)
                         && (bus_wdata[2:0] == 3'b101) && bus_wdata[4];

    // R2
    no_decode_when_disabled_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bus_aen_n |-> !hit);

    // R7
    no_unmasked_source_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((flags & mask & 8'h85) == 8'h00) |-> !irq);

    // R6
    masked_source_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((flags[7] && mask[7]) || (flags[0] && mask[0]) || (flags[2] && mask[2])) |-> irq);

    // R9
    recon_held_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (flags[2] && !soft_rst && !clr_recon_now) |=> flags[2]);

    // R9
    recon_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reconfig_evt && !soft_rst) |=> flags[2]);

    // R10
    diag_clear_on_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && hit && ofs == 4'h1 && diag_evt == 3'b000) |=> (diag_img == 8'h00));

    // R10
    diag_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((diag_evt != 3'b000) && !soft_rst) |=> (diag_img != 8'h00));

    // R11
    cmd_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && hit && ofs == 4'h1 && !soft_rst) |=> cmd_stb);

    // R11
    cmd_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_wr && hit) |=> !cmd_stb);

    // R4
    soft_reset_chk: assert property (@(posedge clk) disable iff (!rst_n)
        soft_rst |=> (mask == 8'h00 && flags == 8'h91 && diag_img == 8'h00 && !cmd_stb));
endmodule

bind nchi_host_if nchi_host_if_chk u_chk (
    .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst), .bus_aen_n(bus_aen_n),
    .bus_rd(bus_rd), .bus_wr(bus_wr), .bus_wdata(bus_wdata),
    .hit(dec_hit), .ofs(dec_ofs), .flags(st_flags), .mask(st_mask),
    .diag_img(dg_img), .diag_evt(diag_evt), .reconfig_evt(reconfig_evt),
    .irq(irq), .cmd_stb(cmd_stb)
);

// File: tb/sim_nchi_host_if.sv
`timescale 1ns/1ps
module sim_nchi_host_if;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic soft_rst = 0, bus_aen_n = 1, bus_rd = 0, bus_wr = 0;
    logic [2:0] base_sel = 3'd0;
    logic [15:0] bus_addr = '0;
    logic [7:0] bus_wdata = '0, bus_rdata, cmd_code;
    logic rx_inh_set = 0, rx_inh_clr = 0, tx_avail_set = 0, tx_avail_clr = 0;
    logic tx_ack_set = 0, tx_ack_clr = 0, reconfig_evt = 0;
    logic [1:0] core_live = 2'b00;
    logic [2:0] diag_evt = 3'b000;
    logic irq, cmd_stb;

    int n_chk = 0, n_fail = 0;
    bit done = 0;

    logic [7:0] m_flags, m_mask, m_rdata, m_code;
    logic [2:0] m_diag;
    logic       m_stb;

    always #10 clk = ~clk;

    nchi_host_if u0 (.*);

    function automatic logic [11:0] f_base(input logic [2:0] s);
        return 12'h020 + {8'h00, s, 1'b0};
    endfunction
    function automatic logic [7:0] f_stat(input logic [7:0] f, input logic [1:0] l);
        return {f[7], l, f[4], f[3], f[2], 1'b0, f[0]};
    endfunction
    function automatic logic [7:0] f_diag(input logic [2:0] d);
        return {d[2], 1'b0, d[1], d[0], 4'h0};
    endfunction
    function automatic logic f_irq(input logic [7:0] f, input logic [7:0] m);
        return (f[7] & m[7]) | (f[2] & m[2]) | (f[0] & m[0]);
    endfunction

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic model_reset();
        m_flags = 8'h91; m_mask = 8'h00; m_diag = 3'b000;
        m_rdata = 8'h00; m_stb = 1'b0; m_code = 8'h00;
    endtask

    // one clock step: model advance, edge, compare
    task automatic step();
        logic h; logic [3:0] o; logic clrf;
        h = !bus_aen_n && (bus_addr[15:4] == f_base(base_sel));
        o = bus_addr[3:0];
        if (soft_rst) model_reset();
        else begin
            if (bus_rd)
                m_rdata = (h && o == 4'h0) ? f_stat(m_flags, core_live) :
                          (h && o == 4'h1) ? f_diag(m_diag) : 8'h00;
            clrf = bus_wr && h && o == 4'h1 && bus_wdata[2:0] == 3'b101;
            if (rx_inh_set) m_flags[7] = 1; else if (rx_inh_clr) m_flags[7] = 0;
            if (tx_avail_set) m_flags[0] = 1; else if (tx_avail_clr) m_flags[0] = 0;
            if (tx_ack_set) m_flags[3] = 1; else if (tx_ack_clr) m_flags[3] = 0;
            if (reconfig_evt) m_flags[2] = 1; else if (clrf && bus_wdata[4]) m_flags[2] = 0;
            if (clrf && bus_wdata[3]) m_flags[4] = 0;
            if (bus_wr && h && o == 4'h0) m_mask = bus_wdata;
            if (bus_rd && h && o == 4'h1) m_diag = 3'b000;
            m_diag = m_diag | diag_evt;
            m_stb = bus_wr && h && o == 4'h1;
            if (m_stb) m_code = bus_wdata;
        end
        @(posedge clk); #1;
        chk(bus_rdata == m_rdata, "R3 read data", bus_rdata, m_rdata);
        chk(irq == f_irq(m_flags, m_mask), "R6 irq", irq, f_irq(m_flags, m_mask));
        chk(cmd_stb == m_stb, "R11 cmd strobe", cmd_stb, m_stb);
        if (m_stb) chk(cmd_code == m_code, "R11 cmd code", cmd_code, m_code);
        bus_rd = 0; bus_wr = 0; soft_rst = 0; diag_evt = 0; reconfig_evt = 0;
        rx_inh_set = 0; rx_inh_clr = 0; tx_avail_set = 0; tx_avail_clr = 0;
        tx_ack_set = 0; tx_ack_clr = 0;
    endtask

    task automatic rd_at(input logic [3:0] o, output logic [7:0] d);
        bus_aen_n = 0; bus_addr = {f_base(base_sel), o}; bus_rd = 1;
        step(); d = bus_rdata;
    endtask
    task automatic wr_at(input logic [3:0] o, input logic [7:0] d);
        bus_aen_n = 0; bus_addr = {f_base(base_sel), o}; bus_wr = 1; bus_wdata = d;
        step();
    endtask

    initial begin
        #(20 * 150000);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        logic [7:0] d;
        void'($urandom(32'd4242));
        model_reset();
        repeat (3) @(posedge clk);
        #1 rst_n = 1;
        chk(irq == 0 && cmd_stb == 0 && bus_rdata == 0, "R4 reset outputs", {irq, cmd_stb, bus_rdata}, 0);

        // R4 / R3 reset image with live bits
        core_live = 2'b10;
        rd_at(4'h0, d); chk(d == 8'hD1, "R4 status reset image", d, 8'hD1);
        rd_at(4'h1, d); chk(d == 8'h00, "R4 diag reset image", d, 8'h00);

        // R6 mask enables transmitter-available
        wr_at(4'h0, 8'h01); chk(irq == 1, "R6 TA unmasked", irq, 1);
        // R7 transmit-acknowledged never interrupts
        tx_ack_set = 1; wr_at(4'h0, 8'h7A); chk(irq == 0, "R7 TMA/other bits masked", irq, 0);
        rd_at(4'h0, d); chk(d[3] == 1, "R5 TMA flag set", d[3], 1);

        // R8 hide and reappear
        rx_inh_set = 1; wr_at(4'h0, 8'h80); chk(irq == 1, "R8 RI shown", irq, 1);
        wr_at(4'h0, 8'h00); chk(irq == 0, "R8 RI hidden", irq, 0);
        wr_at(4'h0, 8'h80); chk(irq == 1, "R8 RI reappears", irq, 1);
        rx_inh_clr = 1; step(); chk(irq == 0, "R5 RI cleared", irq, 0);
        // R5 set beats clear
        tx_avail_set = 1; tx_avail_clr = 1; wr_at(4'h0, 8'h01);
        chk(irq == 1, "R5 set over clear", irq, 1);

        // R9 reconfiguration flag and clear-flags
        reconfig_evt = 1; wr_at(4'h0, 8'h04); chk(irq == 1, "R9 recon irq", irq, 1);
        wr_at(4'h1, 8'h05); chk(irq == 1, "R9 clear without bit4 keeps", irq, 1);
        wr_at(4'h1, 8'h15); chk(irq == 0, "R9 clear recon", irq, 0);
        reconfig_evt = 1; wr_at(4'h1, 8'h15); chk(irq == 1, "R9 event beats clear", irq, 1);
        wr_at(4'h1, 8'h0D); rd_at(4'h0, d); chk(d[4] == 0, "R9 reset flag cleared", d[4], 0);

        // R10 diagnostic sticky bits
        diag_evt = 3'b101; step();
        rd_at(4'h1, d); chk(d == 8'h90, "R10 diag read", d, 8'h90);
        rd_at(4'h1, d); chk(d == 8'h00, "R10 diag cleared", d, 8'h00);
        diag_evt = 3'b010; rd_at(4'h1, d); chk(d == 8'h00, "R10 read during event", d, 8'h00);
        rd_at(4'h1, d); chk(d == 8'h20, "R10 event kept", d, 8'h20);

        // R11 command strobe
        wr_at(4'h1, 8'h3C); chk(cmd_stb == 1 && cmd_code == 8'h3C, "R11 strobe", cmd_code, 8'h3C);
        step(); chk(cmd_stb == 0, "R11 one cycle", cmd_stb, 0);

        // R2 disabled / outside
        bus_aen_n = 1; bus_addr = {f_base(base_sel), 4'h0}; bus_wr = 1; bus_wdata = 8'h00; step();
        chk(irq == 1, "R2 aen high ignores write", irq, 1);
        bus_aen_n = 1; bus_addr = {f_base(base_sel), 4'h0}; bus_rd = 1; step();
        chk(bus_rdata == 8'h00, "R2 aen high read zero", bus_rdata, 0);
        bus_aen_n = 0; bus_addr = {f_base(3'd1), 4'h1}; bus_wr = 1; bus_wdata = 8'h11; step();
        chk(cmd_stb == 0, "R2 outside window", cmd_stb, 0);

        // R12 unused offsets
        wr_at(4'h5, 8'hFF); rd_at(4'h5, d); chk(d == 8'h00, "R12 unused offset", d, 0);

        // R1 moved window
        base_sel = 3'd5;
        rd_at(4'h0, d); chk(d[0] == 1, "R1 new base 0x2A0", d, 8'h01);
        bus_aen_n = 0; bus_addr = 16'h0201; bus_wr = 1; bus_wdata = 8'h22; step();
        chk(cmd_stb == 0, "R1 old base unclaimed", cmd_stb, 0);

        // R4 soft reset
        wr_at(4'h0, 8'h85); reconfig_evt = 1; diag_evt = 3'b111; step();
        soft_rst = 1; step();
        chk(irq == 0, "R4 soft reset irq", irq, 0);
        rd_at(4'h0, d); chk(d == f_stat(8'h91, core_live), "R4 soft reset status", d, f_stat(8'h91, core_live));
        rd_at(4'h1, d); chk(d == 8'h00, "R4 soft reset diag", d, 0);

        // random phase
        for (int i = 0; i < 600; i++) begin
            if (i % 150 == 0) base_sel = 3'($urandom_range(7));
            bus_aen_n = ($urandom_range(99) < 8);
            bus_addr = ($urandom_range(99) < 80) ? {f_base(base_sel), 4'($urandom_range(3))} : 16'($urandom);
            case ($urandom_range(2))
                1: bus_rd = 1;
                2: bus_wr = 1;
                default: ;
            endcase
            bus_wdata = 8'($urandom);
            core_live = 2'($urandom);
            rx_inh_set = ($urandom_range(7) == 0); rx_inh_clr = ($urandom_range(7) == 0);
            tx_avail_set = ($urandom_range(7) == 0); tx_avail_clr = ($urandom_range(7) == 0);
            tx_ack_set = ($urandom_range(7) == 0); tx_ack_clr = ($urandom_range(7) == 0);
            reconfig_evt = ($urandom_range(15) == 0);
            diag_evt = ($urandom_range(3) == 0) ? 3'($urandom) : 3'b000;
            soft_rst = ($urandom_range(99) == 0);
            step();
        end

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule